// File: doc/BRIEF.md
# Shared Last-Level Residency Tracker

This block keeps the tags, and only the tags, of a set-associative shared last-level cache. A directory controller uses it to learn whether a memory block is held on chip, and it is not on a core's per-cycle pipeline. Each request carries a block address, which is a byte address with the 64-byte line offset already removed, and one of two operations.

A **probe** asks whether the block is present and leaves the replacement order alone. An **access** asks the same question. On a hit it makes the line most recently used. On a miss it installs the block and reports the block it pushed out, if there was one. The tracker holds no data, tracks no outstanding misses and sends no invalidations upward when it evicts a line.

A static input turns the tracker off. It then behaves like a cache of size zero: every request misses and nothing is stored. One request is taken per cycle, and its answer is registered and appears in the next cycle together with a valid strobe.

Top module: `res_track`

## Requirements
- R1: A probe (`reqAccess`=0) reports in `rspHit` whether the block is resident, and it changes neither the recency order nor the contents of any set.
- R2: An access (`reqAccess`=1) to a resident block reports `rspHit`=1 with no victim, and makes that block the most recently used block of its set.
- R3: An access that misses installs the block. When its set is full, it replaces the least recently used block of that set.
- R4: When an install replaces a valid block, the response carries `rspVictimValid`=1 and `rspVictimBlock` equal to the full block address of the replaced block. In every other response, `rspVictimValid`=0 and `rspVictimBlock`=0.
- R5: An access miss into a set that still has an empty way fills an empty way and reports `rspVictimValid`=0.
- R6: While `trackOff`=1, every probe and access reports a miss with no victim, and no block is installed or promoted. A later probe with `trackOff`=0 shows that the tracker's contents are unchanged.
- R7: A synchronous reset empties every set, so that every block misses after reset.
- R8: Every cycle with `reqValid`=1 is accepted. `rspValid` is 1 exactly in the cycle after an accepted request and 0 otherwise, including during and right after reset.
- R9: The set is chosen by the low log2(SETS) bits of the block address, and the upper bits form the tag. Blocks in different sets never displace one another, and a set holds at most WAYS blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trackOff | input | 1 | 1 = tracker disabled (always miss, never install) |
| reqValid | input | 1 | A request is presented this cycle |
| reqAccess | input | 1 | 0 = probe, 1 = access |
| reqBlock | input | BLK_W | Block address (line number) |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspHit | output | 1 | Block was resident |
| rspVictimValid | output | 1 | An install displaced a valid block |
| rspVictimBlock | output | BLK_W | Block address of the displaced block |

## Verification
Every result of a request is registered once. Hit, victim-valid, victim block and the response strobe therefore all appear right after the clock edge that accepts the request. The tracker's state also changes at that same edge, so a request presented in the following cycle already sees the update. The bench drives a request shortly after a rising edge, waits for the next rising edge, and compares all four outputs a few nanoseconds later. It compares them against a recency-ordered list per set that it keeps itself. Each request is therefore judged in exactly one cycle, and back-to-back requests test that the state update is visible immediately.

// File: rtl/res_track_pkg.sv
`timescale 1ns/1ps
package res_track_pkg;

  // Strobes the control hands to the datapath for one accepted request.
  typedef struct packed {
    logic touch;    // promote the hitting way to most recently used
    logic install;  // write the request tag into the chosen way
    logic evict;    // the install displaces a valid line
    logic hit;      // lookup hit while the tracker is enabled
  } ctrlStrb_t;

endpackage

// File: rtl/res_track_ctrl.sv
`timescale 1ns/1ps
module res_track_ctrl
  import res_track_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqValid,
  input  logic      reqAccess,
  input  logic      trackOff,
  input  logic      lookupHit,
  input  logic      setHasFree,
  output ctrlStrb_t strb,
  output logic      rspValid,
  output logic      rspHit
);

  logic live;

  always_comb begin
    live         = reqValid & ~trackOff;
    strb.hit     = live & lookupHit;
    strb.touch   = live & reqAccess & lookupHit;
    strb.install = live & reqAccess & ~lookupHit;
    strb.evict   = live & reqAccess & ~lookupHit & ~setHasFree;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspHit   <= strb.hit;
    end
  end

  // R8: a response follows every accepted request one cycle later
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  // R8: no response without a request
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  // R6: while disabled the answer is always a miss
  assert_off_always_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && trackOff) |=> (rspValid && !rspHit));

endmodule

// File: rtl/res_track_dp.sv
`timescale 1ns/1ps
module res_track_dp
  import res_track_pkg::*;
#(
  parameter int BLK_W = 26,
  parameter int SETS  = 64,
  parameter int WAYS  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] reqBlock,
  input  ctrlStrb_t        strb,
  output logic             lookupHit,
  output logic             setHasFree,
  output logic             rspVictimValid,
  output logic [BLK_W-1:0] rspVictimBlock
);

  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = BLK_W - SET_W;
  localparam int FLAT_W = SETS * WAYS * WAY_W;

  logic [SETS-1:0][WAYS-1:0] validQ;
  logic [TAG_W-1:0]          tagQ [SETS][WAYS];
  logic [WAY_W-1:0]          ageQ [SETS][WAYS];

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  hitVec;
  logic [WAY_W-1:0] hitWay, freeWay, lruWay, chosenWay, chosenAge;
  logic [FLAT_W-1:0] ageFlat;

  assign setIdx = reqBlock[SET_W-1:0];
  assign reqTag = reqBlock[BLK_W-1:SET_W];

  // One tag comparator per way of the addressed set.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[setIdx][w] && (tagQ[setIdx][w] == reqTag);
  end

  // Flattened age view used by the replacement-stability check.
  for (genvar s = 0; s < SETS; s++) begin : g_flatS
    for (genvar w = 0; w < WAYS; w++) begin : g_flatW
      assign ageFlat[(s*WAYS + w)*WAY_W +: WAY_W] = ageQ[s][w];
    end
  end

  always_comb begin
    hitWay  = '0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])                                  hitWay  = WAY_W'(w);
      if (!validQ[setIdx][w])                         freeWay = WAY_W'(w);
      if (ageQ[setIdx][w] == WAY_W'(WAYS - 1))        lruWay  = WAY_W'(w);
    end
    lookupHit  = |hitVec;
    setHasFree = ~&validQ[setIdx];
    if (strb.touch)      chosenWay = hitWay;
    else if (setHasFree) chosenWay = freeWay;
    else                 chosenWay = lruWay;
    chosenAge = ageQ[setIdx][chosenWay];
  end

  // Tag, valid and age state; ages form a permutation in every set.
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          ageQ[s][w] <= WAY_W'(w);
          tagQ[s][w] <= '0;
        end
      end
    end else begin
      if (strb.touch || strb.install) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == chosenWay)
            ageQ[setIdx][w] <= '0;
          else if (ageQ[setIdx][w] < chosenAge)
            ageQ[setIdx][w] <= ageQ[setIdx][w] + 1'b1;
        end
      end
      if (strb.install) begin
        validQ[setIdx][chosenWay] <= 1'b1;
        tagQ[setIdx][chosenWay]   <= reqTag;
      end
    end
  end

  // Victim response register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rspVictimValid <= 1'b0;
      rspVictimBlock <= '0;
    end else begin
      rspVictimValid <= strb.evict;
      rspVictimBlock <= strb.evict ? {tagQ[setIdx][lruWay], setIdx} : '0;
    end
  end

  // R1: a cycle that neither touches nor installs leaves recency state alone
  assert_idle_keeps_lru_R1: assert property (@(posedge clk) disable iff (rst)
    !(strb.touch || strb.install) |=> (ageFlat == $past(ageFlat)));

  // R9: a tag is never resident twice in one set
  assert_unique_tag_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hitVec));

  // R4: the reported victim lies in the set of the request that evicted it
  assert_victim_set_R4: assert property (@(posedge clk) disable iff (rst)
    strb.evict |=> (rspVictimValid && rspVictimBlock[SET_W-1:0] == $past(setIdx)));

  // R5: an eviction only happens when the set had no empty way
  assert_free_first_R5: assert property (@(posedge clk) disable iff (rst)
    strb.install |-> (strb.evict == !setHasFree));

  // R2: a hit is never paired with an install
  assert_hit_no_install_R2: assert property (@(posedge clk) disable iff (rst)
    lookupHit |-> !strb.install);

endmodule

// File: rtl/res_track.sv
`timescale 1ns/1ps
module res_track
  import res_track_pkg::*;
#(
  parameter int BLK_W = 26,
  parameter int SETS  = 64,
  parameter int WAYS  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trackOff,
  input  logic             reqValid,
  input  logic             reqAccess,
  input  logic [BLK_W-1:0] reqBlock,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspVictimValid,
  output logic [BLK_W-1:0] rspVictimBlock
);

  ctrlStrb_t strb;
  logic      lookupHit;
  logic      setHasFree;

  res_track_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .reqAccess  (reqAccess),
    .trackOff   (trackOff),
    .lookupHit  (lookupHit),
    .setHasFree (setHasFree),
    .strb       (strb),
    .rspValid   (rspValid),
    .rspHit     (rspHit)
  );

  res_track_dp #(
    .BLK_W (BLK_W),
    .SETS  (SETS),
    .WAYS  (WAYS)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .reqBlock       (reqBlock),
    .strb           (strb),
    .lookupHit      (lookupHit),
    .setHasFree     (setHasFree),
    .rspVictimValid (rspVictimValid),
    .rspVictimBlock (rspVictimBlock)
  );

  // R4: a victim is reported only with a valid miss response
  assert_victim_on_miss_R4: assert property (@(posedge clk) disable iff (rst)
    rspVictimValid |-> (rspValid && !rspHit));

endmodule

// File: tb/tb_res_track.sv
`timescale 1ns/1ps
module tb_res_track;

  localparam int BLK_W = 8;
  localparam int SETS  = 4;
  localparam int WAYS  = 4;
  localparam int NBLK  = 1 << BLK_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             trackOff = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqAccess = 1'b0;
  logic [BLK_W-1:0] reqBlock = '0;
  logic             rspValid, rspHit, rspVictimValid;
  logic [BLK_W-1:0] rspVictimBlock;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench model: per set, resident blocks ordered most recent first.
  int mdl [SETS][WAYS];
  int cnt [SETS];

  always #10 clk = ~clk;  // 50 MHz

  res_track #(.BLK_W(BLK_W), .SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst(rst), .trackOff(trackOff), .reqValid(reqValid),
    .reqAccess(reqAccess), .reqBlock(reqBlock), .rspValid(rspValid),
    .rspHit(rspHit), .rspVictimValid(rspVictimValid),
    .rspVictimBlock(rspVictimBlock)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic mdlOp(input bit acc, input int blk, input bit off,
                       output bit eHit, output bit eVv, output int eVb);
    int s, pos, last;
    bit found;
    s = blk % SETS;
    found = 1'b0;
    pos = 0;
    for (int i = 0; i < cnt[s]; i++) if (mdl[s][i] == blk) begin found = 1'b1; pos = i; end
    eHit = !off && found;
    eVv = 1'b0;
    eVb = 0;
    if (!off && acc) begin
      if (found) last = pos;
      else if (cnt[s] < WAYS) begin last = cnt[s]; cnt[s]++; end
      else begin last = WAYS - 1; eVv = 1'b1; eVb = mdl[s][WAYS-1]; end
      for (int i = last; i > 0; i--) mdl[s][i] = mdl[s][i-1];
      mdl[s][0] = blk;
    end
  endtask

  // One request; response checked after the next rising edge.
  task automatic doOp(input bit acc, input int blk, input bit off, input string tag);
    bit eHit, eVv;
    int eVb;
    string req;
    mdlOp(acc, blk, off, eHit, eVv, eVb);
    if (tag != "") req = tag;
    else if (off) req = "R6";
    else if (!acc) req = "R1";
    else if (eHit) req = "R2";
    else if (eVv) req = "R3 R4";
    else req = "R5";
    reqValid = 1'b1; reqAccess = acc; reqBlock = BLK_W'(blk); trackOff = off;
    @(posedge clk); #2;
    reqValid = 1'b0;
    check("R8", "rspValid", int'(rspValid), 1);
    check(req, "rspHit", int'(rspHit), int'(eHit));
    check(req, "rspVictimValid", int'(rspVictimValid), int'(eVv));
    check(req, "rspVictimBlock", int'(rspVictimBlock), eVb);
  endtask

  task automatic idle(input string req);
    @(posedge clk); #2;
    check(req, "rspValid idle", int'(rspValid), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed, blk;
    for (int s = 0; s < SETS; s++) cnt[s] = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R8", "rspValid in reset", int'(rspValid), 0);
    rst = 1'b0;
    idle("R8");

    // R7: empty after reset
    for (int b = 0; b < 16; b++) doOp(1'b0, b * 13, 1'b0, "R7");

    // R5 then R3/R4: fill set 1, overflow it
    for (int t = 0; t < WAYS + 2; t++) doOp(1'b1, t * SETS + 1, 1'b0, "");
    // R1: probe everything in set 1, then evict: LRU unaffected by probes
    for (int t = 0; t < WAYS + 2; t++) doOp(1'b0, t * SETS + 1, 1'b0, "R1");
    doOp(1'b1, 40 * SETS + 1, 1'b0, "R1");
    // R2: promote the current LRU, next miss evicts the one after it
    doOp(1'b1, 3 * SETS + 1, 1'b0, "R2");
    doOp(1'b1, 41 * SETS + 1, 1'b0, "R2");
    // R9: other sets undisturbed by set 1 traffic
    for (int t = 0; t < WAYS; t++) doOp(1'b1, t * SETS + 2, 1'b0, "R9");
    for (int t = 0; t < 8; t++) doOp(1'b0, t * SETS + 1, 1'b0, "R9");
    idle("R8");

    // R6: disabled traffic never installs or promotes
    for (int t = 0; t < 8; t++) doOp(1'b1, 50 * SETS + t, 1'b1, "R6");
    doOp(1'b1, 5 * SETS + 1, 1'b1, "R6");
    for (int t = 0; t < 8; t++) doOp(1'b0, 50 * SETS + t, 1'b0, "R6");
    doOp(1'b1, 60 * SETS + 1, 1'b0, "R6");

    // Sweep: every block of a small tag range, twice, by access then probe
    for (int pass = 0; pass < 2; pass++)
      for (int b = 0; b < 48; b++) doOp(1'b1, b, 1'b0, "");
    for (int b = 0; b < 48; b++) doOp(1'b0, b, 1'b0, "");

    // Mixed pseudo-random traffic with conflicts, probes and disabled cycles
    seed = 12345;
    for (int n = 0; n < 4000; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      blk = (seed >> 8) % 40;
      if (((seed >> 4) & 15) == 0) idle("R8");
      doOp(((seed >> 2) & 3) != 0, blk, ((seed >> 20) & 31) == 0, "");
    end

    // R7: reset again empties all sets
    rst = 1'b1;
    @(posedge clk); #2;
    rst = 1'b0;
    for (int s = 0; s < SETS; s++) cnt[s] = 0;
    for (int b = 0; b < 40; b++) doOp(1'b0, b, 1'b0, "R7");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule